// File: doc/BRIEF.md
# JTAG Test Port Ownership Selector

This block decides which of three test access ports takes over a shared set of JTAG pads: the lifecycle port, the processor debug port or the design-for-test port. A two-bit ownership code is sampled from two strap pads and held in a register. The code is decoded into a single owner. The owner receives the clock, mode select, reset and data-in pad levels. The TDO pad is driven from the owner's data-out and drive-enable response.

Two lifecycle permissions gate the choice: a debug permission and a test permission. Each is a single "on" bit that crosses into the block's clock domain through a two-flop synchroniser. The processor port only works with debug permission, and the test port only works with test permission. The lifecycle port needs no permission. The block also latches a second pair of test strap pins once, when strap sampling and test permission coincide, and flags the capture as valid until reset.

Top module: `jtag_strap_sel`

## Requirements
- R1: The debug permission and the test permission each take effect exactly two clock edges after they change at the input; before that the previous level governs all gating and sampling.
- R2: Ownership bit 0 is loaded from strap pad bit 0 on a clock edge where strap sampling is requested, or where the synchronised test permission is on and the hold input is low.
- R3: Ownership bit 1 is loaded from strap pad bit 1 only on an edge that meets the R2 condition while the synchronised debug permission is on; otherwise bit 1 keeps its value.
- R4: While the hold input is high and strap sampling is not requested, the ownership code does not change.
- R5: Ownership code 1 selects the lifecycle port, 2 the processor port, 3 the test port and 0 no port. The selected port receives a 4-bit request with bit 3 = TCK pad, bit 2 = TMS pad, bit 1 = TRST pad, bit 0 = TDI pad.
- R6: Every port that is not selected receives a request of all zeros. The processor port also gets zeros without synchronised debug permission, and the test port gets zeros without synchronised test permission.
- R7: While scan mode is high, request bit 1 of the active port carries the system reset level instead of the TRST pad.
- R8: The TDO pad output equals bit 1 and the TDO pad enable equals bit 0 of the active port's response; with no active port both are 0.
- R9: On an edge where strap sampling is requested and synchronised test permission is on, the two test strap pins are captured and the valid flag is set. The valid flag then stays set until reset, and the captured value changes only on another such edge.
- R10: While reset is asserted, the ownership code, the captured test straps, the valid flag and both synchronised permissions are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also the TRST source in scan mode |
| scan_mode_i | input | 1 | Scan mode active |
| dbg_allow_i | input | 1 | Lifecycle debug permission, asynchronous |
| test_allow_i | input | 1 | Lifecycle test permission, asynchronous |
| strap_sample_i | input | 1 | Request to sample the strap pads |
| sel_hold_i | input | 1 | Freeze the ownership code unless sampling is requested |
| own_strap_i | input | 2 | Ownership strap pads |
| test_strap_i | input | 2 | Test strap pins |
| pad_tck_i | input | 1 | TCK pad |
| pad_tms_i | input | 1 | TMS pad |
| pad_trst_i | input | 1 | TRST pad |
| pad_tdi_i | input | 1 | TDI pad |
| lc_req_o | output | 4 | Request to the lifecycle port {tck,tms,trst,tdi} |
| cpu_req_o | output | 4 | Request to the processor port |
| dft_req_o | output | 4 | Request to the test port |
| lc_rsp_i | input | 2 | Lifecycle port response {tdo,oe} |
| cpu_rsp_i | input | 2 | Processor port response {tdo,oe} |
| dft_rsp_i | input | 2 | Test port response {tdo,oe} |
| pad_tdo_o | output | 1 | TDO pad output |
| pad_tdo_oe_o | output | 1 | TDO pad drive enable |
| test_strap_o | output | 2 | Captured test straps |
| test_strap_vld_o | output | 1 | Captured test straps are valid |

## Verification
The bench targets a strap sample taken while debug permission is off. A design that loaded both bits would hand the processor or test port to a code that was never fully authorised. It also toggles the permissions right before sampling edges. A synchroniser with the wrong depth then gates or samples one cycle early or late. Scan mode is driven with the TRST pad opposite to reset, so forwarding the pad shows up as a wrong bit 1. The valid flag is watched while test permission drops, and a design that cleared or recaptured it there would show a changed strap output.

// File: rtl/jsel_pkg.sv
package jsel_pkg;
  localparam int unsigned SelW = 2;
  localparam int unsigned ReqW = 4;
  localparam int unsigned RspW = 2;

  typedef enum logic [SelW-1:0] {
    OWN_NONE = 2'd0,
    OWN_LC   = 2'd1,
    OWN_CPU  = 2'd2,
    OWN_DFT  = 2'd3
  } owner_e;

  typedef struct packed {
    logic tck;
    logic tms;
    logic trst;
    logic tdi;
  } jreq_t;

  typedef struct packed {
    logic tdo;
    logic oe;
  } jrsp_t;
endpackage

// File: rtl/jsel_sync.sv
module jsel_sync #(
  parameter int unsigned Stages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [Stages-1:0] stage_q;
  logic [Stages-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[Stages-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[Stages-1];
endmodule

// File: rtl/jsel_strap_reg.sv
module jsel_strap_reg
  import jsel_pkg::*;
#(
  parameter int unsigned TestW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_sample_i,
  input  logic             sel_hold_i,
  input  logic             dbg_ok_i,
  input  logic             test_ok_i,
  input  logic [SelW-1:0]  own_strap_i,
  input  logic [TestW-1:0] test_strap_i,
  output owner_e           owner_o,
  output logic [TestW-1:0] test_strap_o,
  output logic             test_vld_o
);
  logic [SelW-1:0]  own_q, own_d;
  logic [TestW-1:0] tst_q, tst_d;
  logic             vld_q, vld_d;
  logic             sample_now;
  logic             test_cap;

  assign sample_now = strap_sample_i || (test_ok_i && !sel_hold_i);
  assign test_cap   = strap_sample_i && test_ok_i;

  always_comb begin
    own_d = own_q;
    if (sample_now) begin
      own_d[0] = own_strap_i[0];
      if (dbg_ok_i) own_d = own_strap_i;
    end
  end

  always_comb begin
    tst_d = tst_q;
    vld_d = vld_q;
    if (test_cap) begin
      tst_d = test_strap_i;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      tst_q <= '0;
      vld_q <= 1'b0;
    end else begin
      own_q <= own_d;
      tst_q <= tst_d;
      vld_q <= vld_d;
    end
  end

  assign owner_o      = owner_e'(own_q);
  assign test_strap_o = tst_q;
  assign test_vld_o   = vld_q;

  a_r4_hold_freezes_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_hold_i && !strap_sample_i |=> $stable(own_q));
  a_r3_bit1_needs_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_ok_i |=> $stable(own_q[1]));
  a_r2_bit0_follows_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_sample_i |=> own_q[0] == $past(own_strap_i[0]));
  a_r9_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> vld_q);
  a_r9_capture_only_when_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strap_sample_i && test_ok_i) |=> $stable(tst_q));
endmodule

// File: rtl/jsel_route.sv
module jsel_route
  import jsel_pkg::*;
(
  input  owner_e          owner_i,
  input  logic            dbg_ok_i,
  input  logic            test_ok_i,
  input  logic            scan_mode_i,
  input  logic            sys_rst_ni,
  input  jreq_t           pad_req_i,
  input  jrsp_t           lc_rsp_i,
  input  jrsp_t           cpu_rsp_i,
  input  jrsp_t           dft_rsp_i,
  output jreq_t           lc_req_o,
  output jreq_t           cpu_req_o,
  output jreq_t           dft_req_o,
  output jrsp_t           pad_rsp_o
);
  logic  lc_act, cpu_act, dft_act;
  jreq_t fwd;

  assign lc_act  = (owner_i == OWN_LC);
  assign cpu_act = (owner_i == OWN_CPU) && dbg_ok_i;
  assign dft_act = (owner_i == OWN_DFT) && test_ok_i;

  always_comb begin
    fwd = pad_req_i;
    if (scan_mode_i) fwd.trst = sys_rst_ni;
  end

  assign lc_req_o  = lc_act  ? fwd : '0;
  assign cpu_req_o = cpu_act ? fwd : '0;
  assign dft_req_o = dft_act ? fwd : '0;

  always_comb begin
    pad_rsp_o = '0;
    unique case (1'b1)
      lc_act:  pad_rsp_o = lc_rsp_i;
      cpu_act: pad_rsp_o = cpu_rsp_i;
      dft_act: pad_rsp_o = dft_rsp_i;
      default: pad_rsp_o = '0;
    endcase
  end
endmodule

// File: rtl/jtag_strap_sel.sv
module jtag_strap_sel
  import jsel_pkg::*;
#(
  parameter int unsigned SyncStages = 2,
  parameter int unsigned TestW      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_mode_i,
  input  logic             dbg_allow_i,
  input  logic             test_allow_i,
  input  logic             strap_sample_i,
  input  logic             sel_hold_i,
  input  logic [1:0]       own_strap_i,
  input  logic [TestW-1:0] test_strap_i,
  input  logic             pad_tck_i,
  input  logic             pad_tms_i,
  input  logic             pad_trst_i,
  input  logic             pad_tdi_i,
  output logic [3:0]       lc_req_o,
  output logic [3:0]       cpu_req_o,
  output logic [3:0]       dft_req_o,
  input  logic [1:0]       lc_rsp_i,
  input  logic [1:0]       cpu_rsp_i,
  input  logic [1:0]       dft_rsp_i,
  output logic             pad_tdo_o,
  output logic             pad_tdo_oe_o,
  output logic [TestW-1:0] test_strap_o,
  output logic             test_strap_vld_o
);
  logic   dbg_ok, test_ok;
  owner_e owner;
  jreq_t  pad_req, lc_req, cpu_req, dft_req;
  jrsp_t  pad_rsp;

  jsel_sync #(.Stages(SyncStages)) u_dbg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dbg_allow_i), .q_o(dbg_ok));
  jsel_sync #(.Stages(SyncStages)) u_test_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(test_allow_i), .q_o(test_ok));

  jsel_strap_reg #(.TestW(TestW)) u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .strap_sample_i(strap_sample_i), .sel_hold_i(sel_hold_i),
    .dbg_ok_i(dbg_ok), .test_ok_i(test_ok),
    .own_strap_i(own_strap_i), .test_strap_i(test_strap_i),
    .owner_o(owner), .test_strap_o(test_strap_o), .test_vld_o(test_strap_vld_o));

  assign pad_req = '{tck: pad_tck_i, tms: pad_tms_i, trst: pad_trst_i, tdi: pad_tdi_i};

  jsel_route u_route (
    .owner_i(owner), .dbg_ok_i(dbg_ok), .test_ok_i(test_ok),
    .scan_mode_i(scan_mode_i), .sys_rst_ni(rst_ni), .pad_req_i(pad_req),
    .lc_rsp_i(jrsp_t'(lc_rsp_i)), .cpu_rsp_i(jrsp_t'(cpu_rsp_i)),
    .dft_rsp_i(jrsp_t'(dft_rsp_i)),
    .lc_req_o(lc_req), .cpu_req_o(cpu_req), .dft_req_o(dft_req),
    .pad_rsp_o(pad_rsp));

  assign lc_req_o     = lc_req;
  assign cpu_req_o    = cpu_req;
  assign dft_req_o    = dft_req;
  assign pad_tdo_o    = pad_rsp.tdo;
  assign pad_tdo_oe_o = pad_rsp.oe;

  a_r1_dbg_two_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_ok) |-> $past(dbg_allow_i, 2));
  a_r1_test_two_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_ok) |-> $past(test_allow_i, 2));
  a_r6_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|lc_req_o, |cpu_req_o, |dft_req_o}));
  a_r6_cpu_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_ok |-> cpu_req_o == 4'b0);
  a_r8_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_req_o == 4'b0 && cpu_req_o == 4'b0 && dft_req_o == 4'b0 &&
     (pad_tck_i || pad_tms_i || pad_tdi_i)) |-> !pad_tdo_oe_o && !pad_tdo_o);
  a_r7_scan_trst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_mode_i |-> !lc_req_o[1] || owner == OWN_LC);
endmodule

// File: tb/jtag_strap_sel_tb.sv
`timescale 1ns/1ps
module jtag_strap_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic scan, dbg_a, test_a, smp, hold;
  logic [1:0] own_p, tst_p, lc_rsp, cpu_rsp, dft_rsp;
  logic tck, tms, trst, tdi;
  logic [3:0] lc_req, cpu_req, dft_req;
  logic tdo, tdo_oe, vld;
  logic [1:0] tst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  int m_dbg1, m_dbg2, m_tst1, m_tst2;
  int m_own, m_ts, m_vld;

  always #2.5 clk = ~clk;

  jtag_strap_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scan_mode_i(scan),
    .dbg_allow_i(dbg_a), .test_allow_i(test_a),
    .strap_sample_i(smp), .sel_hold_i(hold),
    .own_strap_i(own_p), .test_strap_i(tst_p),
    .pad_tck_i(tck), .pad_tms_i(tms), .pad_trst_i(trst), .pad_tdi_i(tdi),
    .lc_req_o(lc_req), .cpu_req_o(cpu_req), .dft_req_o(dft_req),
    .lc_rsp_i(lc_rsp), .cpu_rsp_i(cpu_rsp), .dft_rsp_i(dft_rsp),
    .pad_tdo_o(tdo), .pad_tdo_oe_o(tdo_oe),
    .test_strap_o(tst_o), .test_strap_vld_o(vld));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int fwd_req();
    int tr;
    tr = scan ? int'(rst_n) : int'(trst);
    return (int'(tck) << 3) | (int'(tms) << 2) | (tr << 1) | int'(tdi);
  endfunction

  task automatic compare();
    int e_lc, e_cpu, e_dft, e_pad;
    e_lc  = (m_own == 1) ? fwd_req() : 0;
    e_cpu = (m_own == 2 && m_dbg2 == 1) ? fwd_req() : 0;
    e_dft = (m_own == 3 && m_tst2 == 1) ? fwd_req() : 0;
    e_pad = 0;
    if (m_own == 1) e_pad = int'(lc_rsp);
    else if (m_own == 2 && m_dbg2 == 1) e_pad = int'(cpu_rsp);
    else if (m_own == 3 && m_tst2 == 1) e_pad = int'(dft_rsp);
    check(int'(lc_req) == e_lc,  "R5 R7 R2 R4 lifecycle request", int'(lc_req), e_lc);
    check(int'(cpu_req) == e_cpu, "R6 R1 R3 processor request", int'(cpu_req), e_cpu);
    check(int'(dft_req) == e_dft, "R6 R1 R3 test request", int'(dft_req), e_dft);
    check(int'({tdo, tdo_oe}) == e_pad, "R8 tdo pad", int'({tdo, tdo_oe}), e_pad);
    check(int'({vld, tst_o}) == ((m_vld << 2) | m_ts), "R9 test straps",
          int'({vld, tst_o}), (m_vld << 2) | m_ts);
  endtask

  task automatic model_edge();
    bit samp;
    if (!rst_n) begin
      m_dbg1 = 0; m_dbg2 = 0; m_tst1 = 0; m_tst2 = 0;
      m_own = 0; m_ts = 0; m_vld = 0;
      return;
    end
    samp = smp || (m_tst2 == 1 && !hold);
    if (samp) begin
      if (m_dbg2 == 1) m_own = int'(own_p);
      else m_own = (m_own & 2) | int'(own_p[0]);
    end
    if (smp && m_tst2 == 1) begin
      m_ts = int'(tst_p);
      m_vld = 1;
    end
    m_dbg2 = m_dbg1; m_dbg1 = int'(dbg_a);
    m_tst2 = m_tst1; m_tst1 = int'(test_a);
  endtask

  // drive at negedge, check shortly after, then advance the model at posedge
  task automatic step();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic rand_pads();
    {tck, tms, trst, tdi} = 4'($urandom);
    own_p   = 2'($urandom);
    tst_p   = 2'($urandom);
    lc_rsp  = 2'($urandom);
    cpu_rsp = 2'($urandom);
    dft_rsp = 2'($urandom);
  endtask

  initial begin
    rst_n = 1'b0; scan = 0; dbg_a = 0; test_a = 0; smp = 0; hold = 0;
    own_p = 0; tst_p = 0; tck = 0; tms = 0; trst = 0; tdi = 0;
    lc_rsp = 0; cpu_rsp = 0; dft_rsp = 0;
    m_dbg1 = 0; m_dbg2 = 0; m_tst1 = 0; m_tst2 = 0; m_own = 0; m_ts = 0; m_vld = 0;
    @(negedge clk);
    dbg_a = 1; test_a = 1; smp = 1; own_p = 3; tst_p = 3; tck = 1; tdi = 1;
    for (int i = 0; i < 4; i++) begin
      #1;
      // R10: everything cleared while reset is held
      check(lc_req == 0 && cpu_req == 0 && dft_req == 0 && !tdo_oe && !vld && tst_o == 0,
            "R10 reset state", int'({vld, tst_o, tdo_oe}), 0);
      @(negedge clk);
    end
    rst_n = 1'b1; dbg_a = 0; test_a = 0; smp = 0;
    // R3: sample code 3 without debug permission -> only bit 0 loads (code 1)
    smp = 1; own_p = 3; step(); smp = 0;
    step();
    // R1: raise debug permission, sample code 2 one edge too early then on time
    dbg_a = 1; step();
    smp = 1; own_p = 2; step();   // dbg sync not yet on -> bit1 kept
    step();                       // now on -> code 2
    smp = 0; step();
    // R7: scan mode replaces trst with reset level
    scan = 1; trst = 0; tck = 1; step(); step(); scan = 0;
    // R9: test capture, then permission drop keeps valid
    test_a = 1; step(); step(); tst_p = 2; smp = 1; step(); smp = 0;
    test_a = 0; tst_p = 1; step(); step(); step(); smp = 1; step(); smp = 0; step();
    // R4: hold with test permission on
    test_a = 1; step(); step(); hold = 1; own_p = 1;
    for (int i = 0; i < 6; i++) step();
    hold = 0; step(); step();
    // mixed stimulus against the reference model
    for (int i = 0; i < 4000; i++) begin
      rand_pads();
      scan = ($urandom % 4) == 0;
      hold = ($urandom % 2) == 0;
      smp  = ($urandom % 8) == 0;
      if (($urandom % 24) == 0) dbg_a  = ~dbg_a;
      if (($urandom % 24) == 0) test_a = ~test_a;
      if (i == 2000) begin
        rst_n = 1'b0;
        #1 model_edge();
      end
      if (i == 2003) rst_n = 1'b1;
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule